// File: doc/BRIEF.md
# I2C Arbitration and Bus-Error Monitor

This block sits beside a two-wire serial bus controller and watches the shared clock and data lines. It compares them against what the local controller wants to drive and against the controller's current role and bit phase. It reports two kinds of fault. The first is lost arbitration: the device releases the data line high, but another agent holds it low. The second is an illegal data transition while the clock is high in the middle of a transfer, which is either a misplaced START or a misplaced STOP.

The raw line inputs pass through a multi-stage synchronizer before any edge is detected. Arbitration is compared only at a synchronized clock rising edge, and only in the role and phase combinations where the device actually drives data. On a loss, the block raises a sticky flag and a one-cycle pulse that tells the sequencer to fall back to slave mode. It also raises a request to release both lines, which it holds until the sequencer reports the idle phase. Each flag has its own clear input. One shared enable gates the combined interrupt. The sequencer marks the bus window between the first address bit and the final ACK by a phase other than idle; outside that window, transitions while the clock is high are legal START and STOP conditions.

Top module: `i2c_bus_guard`

## Requirements
- R1: During and right after reset, every output is 0. The synchronizer and the previous-sample registers start at the idle bus level (both lines high).
- R2: The SCL and SDA pins are synchronized through SYNC_STAGES (default 2) registers. At a synchronized SCL rising edge, arbitration is lost when drive_high is 1 and the synchronized SDA is 0. The lost flag becomes visible three clock edges after the SCL pin goes high (default parameters).
- R3: Arbitration is compared only in these combinations of role_master, role_tx and phase (phase code: 0 idle, 1 address, 2 data, 3 ACK). Master transmit checks address and data. Master receive checks address and ACK. Slave transmit checks data. Slave receive checks ACK. No other combination, and never phase 0, sets the flag.
- R4: No arbitration loss is reported when drive_high is 0 or when the synchronized SDA is high at the SCL rising edge.
- R5: to_slave_pulse is high for exactly one cycle, in the cycle where arb_lost_flag first becomes 1.
- R6: release_req rises together with the arbitration flag. It stays high until a cycle in which phase is 0, and falls on the following edge.
- R7: While synchronized SCL is high in two consecutive samples and phase is not 0, a synchronized SDA change in either direction sets bus_err_flag.
- R8: With phase 0, SDA changes while SCL is high set no flag.
- R9: clr_arb clears only arb_lost_flag and clr_berr clears only bus_err_flag. A new event in the same cycle as its clear leaves the flag set.
- R10: irq is 1 exactly when err_irq_en is 1 and at least one of the two flags is 1.
- R11: An SCL rising edge with SDA held steady never sets bus_err_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_pin | input | 1 | Raw clock line level |
| sda_pin | input | 1 | Raw data line level |
| drive_high | input | 1 | Local controller is releasing SDA high this bit |
| role_master | input | 1 | 1 master, 0 slave |
| role_tx | input | 1 | 1 transmitter, 0 receiver |
| phase | input | 2 | Bit phase: 0 idle, 1 address, 2 data, 3 ACK |
| clr_arb | input | 1 | Clear for the arbitration flag |
| clr_berr | input | 1 | Clear for the bus-error flag |
| err_irq_en | input | 1 | Shared error interrupt enable |
| arb_lost_flag | output | 1 | Sticky lost-arbitration status |
| bus_err_flag | output | 1 | Sticky misplaced START/STOP status |
| release_req | output | 1 | Request to release SCL and SDA |
| to_slave_pulse | output | 1 | One-cycle request to revert to slave mode |
| irq | output | 1 | Error interrupt |

## Verification
A wrong edge-detector or synchronizer state shows up as a flag that appears one edge too early or too late after a pin change, or in the wrong role and phase combination. The checks fall three edges after the pin moves, so such a fault is visible within four cycles. A stuck release or pulse register shows either as a pulse longer than one cycle or as release_req still high one edge after the phase returns to idle. A flag register that clears the wrong bit shows as the other flag dropping at the clear.

// File: rtl/bg_pkg.sv
package bg_pkg;
   localparam logic [1:0] PH_IDLE = 2'd0;
   localparam logic [1:0] PH_ADDR = 2'd1;
   localparam logic [1:0] PH_DATA = 2'd2;
   localparam logic [1:0] PH_ACK  = 2'd3;
endpackage

// File: rtl/bg_sync.sv
module bg_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      if (STAGES < 2) $error("bg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bg_arb_check.sv
module bg_arb_check
   import bg_pkg::*;
(
   input  logic       scl_rise,
   input  logic       sda_s,
   input  logic       drive_high,
   input  logic       role_master,
   input  logic       role_tx,
   input  logic [1:0] phase,
   output logic       lost
);
   logic gate;

   always_comb begin
      unique case ({role_master, role_tx})
         2'b11:   gate = (phase == PH_ADDR) || (phase == PH_DATA);
         2'b10:   gate = (phase == PH_ADDR) || (phase == PH_ACK);
         2'b01:   gate = (phase == PH_DATA);
         default: gate = (phase == PH_ACK);
      endcase
   end

   assign lost = scl_rise && gate && drive_high && !sda_s;
endmodule

// File: rtl/bg_berr_check.sv
module bg_berr_check
   import bg_pkg::*;
(
   input  logic       scl_s,
   input  logic       scl_q,
   input  logic       sda_s,
   input  logic       sda_q,
   input  logic [1:0] phase,
   output logic       misplaced
);
   logic scl_held_high;
   logic sda_moved;

   assign scl_held_high = scl_s && scl_q;
   assign sda_moved     = sda_s ^ sda_q;
   assign misplaced     = scl_held_high && sda_moved && (phase != PH_IDLE);
endmodule

// File: rtl/bg_flag.sv
module bg_flag #(
   parameter bit CLEAR_WINS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   generate
      if (CLEAR_WINS) begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= 1'b0;
            else if (clr) q <= 1'b0;
            else if (set) q <= 1'b1;
         end
      end else begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= 1'b0;
            else if (set) q <= 1'b1;
            else if (clr) q <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/i2c_bus_guard.sv
module i2c_bus_guard
   import bg_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit CLEAR_WINS  = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_pin,
   input  logic       sda_pin,
   input  logic       drive_high,
   input  logic       role_master,
   input  logic       role_tx,
   input  logic [1:0] phase,
   input  logic       clr_arb,
   input  logic       clr_berr,
   input  logic       err_irq_en,
   output logic       arb_lost_flag,
   output logic       bus_err_flag,
   output logic       release_req,
   output logic       to_slave_pulse,
   output logic       irq
);
   localparam int NLINES = 2;

   initial begin
      if (SYNC_STAGES < 2) $error("i2c_bus_guard: SYNC_STAGES below 2");
   end

   logic [NLINES-1:0] pins_raw;
   logic [NLINES-1:0] pins_s;
   logic [NLINES-1:0] pins_q;
   logic scl_s, sda_s, scl_q, sda_q;
   logic scl_rise;
   logic arb_hit, berr_hit;

   assign pins_raw = {sda_pin, scl_pin};

   generate
      for (genvar i = 0; i < NLINES; i++) begin : g_sync
         bg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (pins_raw[i]),
            .q    (pins_s[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pins_q <= '1;
      else        pins_q <= pins_s;
   end

   assign scl_s    = pins_s[0];
   assign sda_s    = pins_s[1];
   assign scl_q    = pins_q[0];
   assign sda_q    = pins_q[1];
   assign scl_rise = scl_s && !scl_q;

   bg_arb_check u_arb (
      .scl_rise   (scl_rise),
      .sda_s      (sda_s),
      .drive_high (drive_high),
      .role_master(role_master),
      .role_tx    (role_tx),
      .phase      (phase),
      .lost       (arb_hit)
   );

   bg_berr_check u_berr (
      .scl_s    (scl_s),
      .scl_q    (scl_q),
      .sda_s    (sda_s),
      .sda_q    (sda_q),
      .phase    (phase),
      .misplaced(berr_hit)
   );

   bg_flag #(.CLEAR_WINS(CLEAR_WINS)) u_arb_flag (
      .clk(clk), .rst_n(rst_n), .set(arb_hit), .clr(clr_arb), .q(arb_lost_flag)
   );

   bg_flag #(.CLEAR_WINS(CLEAR_WINS)) u_berr_flag (
      .clk(clk), .rst_n(rst_n), .set(berr_hit), .clr(clr_berr), .q(bus_err_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_slave_pulse <= 1'b0;
         release_req    <= 1'b0;
      end else begin
         to_slave_pulse <= arb_hit && !arb_lost_flag;
         if (arb_hit)                release_req <= 1'b1;
         else if (phase == PH_IDLE)  release_req <= 1'b0;
      end
   end

   assign irq = err_irq_en && (arb_lost_flag || bus_err_flag);
endmodule

// File: rtl/bg_guard_chk.sv
module bg_guard_chk
   import bg_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       drive_high,
   input logic [1:0] phase,
   input logic       err_irq_en,
   input logic       sda_s,
   input logic       sda_q,
   input logic       arb_lost_flag,
   input logic       bus_err_flag,
   input logic       release_req,
   input logic       to_slave_pulse,
   input logic       irq
);
   assert_pulse_has_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      to_slave_pulse |-> arb_lost_flag);

   assert_flag_rise_pulses_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_lost_flag) |-> to_slave_pulse);

   assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      to_slave_pulse |=> !to_slave_pulse);

   assert_loss_needs_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_lost_flag) |-> $past(drive_high));

   assert_release_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (release_req && phase == PH_IDLE) |=> !release_req);

   assert_berr_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_err_flag) |-> $past(phase != PH_IDLE));

   assert_berr_needs_sda_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_err_flag) |-> $past(sda_s != sda_q));

   assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !err_irq_en |-> !irq);
endmodule

bind i2c_bus_guard bg_guard_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .drive_high    (drive_high),
   .phase         (phase),
   .err_irq_en    (err_irq_en),
   .sda_s         (sda_s),
   .sda_q         (sda_q),
   .arb_lost_flag (arb_lost_flag),
   .bus_err_flag  (bus_err_flag),
   .release_req   (release_req),
   .to_slave_pulse(to_slave_pulse),
   .irq           (irq)
);

// File: tb/i2c_bus_guard_tb.sv
module i2c_bus_guard_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 19;

   // entry: {kind, master, tx, phase[1:0], drive, sda0, sda1, exp_arb, exp_berr}
   // kind 0: SCL rises with SDA at sda0; kind 1: SDA goes sda0 -> sda1 while SCL high
   localparam logic [9:0] VEC [NVEC] = '{
      10'b0_1_1_01_1_0_0_1_0,
      10'b0_1_1_10_1_0_0_1_0,
      10'b0_1_1_11_1_0_0_0_0,
      10'b0_1_0_01_1_0_0_1_0,
      10'b0_1_0_10_1_0_0_0_0,
      10'b0_1_0_11_1_0_0_1_0,
      10'b0_0_1_10_1_0_0_1_0,
      10'b0_0_1_01_1_0_0_0_0,
      10'b0_0_0_11_1_0_0_1_0,
      10'b0_0_0_10_1_0_0_0_0,
      10'b0_1_1_10_0_0_0_0_0,
      10'b0_1_1_10_1_1_1_0_0,
      10'b0_1_1_00_1_0_0_0_0,
      10'b1_1_1_10_0_1_0_0_1,
      10'b1_0_0_10_0_0_1_0_1,
      10'b1_0_1_11_0_0_1_0_1,
      10'b1_1_1_00_0_1_0_0_0,
      10'b1_0_0_00_0_0_1_0_0,
      10'b1_1_1_01_0_1_1_0_0
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_pin = 1'b1, sda_pin = 1'b1;
   logic drive_high = 1'b0, role_master = 1'b0, role_tx = 1'b0;
   logic [1:0] phase = 2'd0;
   logic clr_arb = 1'b0, clr_berr = 1'b0, err_irq_en = 1'b1;
   logic arb_lost_flag, bus_err_flag, release_req, to_slave_pulse, irq;

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_bus_guard u_dut (
      .clk(clk), .rst_n(rst_n), .scl_pin(scl_pin), .sda_pin(sda_pin),
      .drive_high(drive_high), .role_master(role_master), .role_tx(role_tx),
      .phase(phase), .clr_arb(clr_arb), .clr_berr(clr_berr),
      .err_irq_en(err_irq_en), .arb_lost_flag(arb_lost_flag),
      .bus_err_flag(bus_err_flag), .release_req(release_req),
      .to_slave_pulse(to_slave_pulse), .irq(irq)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0d exp=%0d", req, got, exp);
      end
   endtask

   task automatic clear_both();
      clr_arb = 1'b1; clr_berr = 1'b1;
      step(1);
      clr_arb = 1'b0; clr_berr = 1'b0;
      step(1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         checks++;
         $display("FAIL watchdog got=0 exp=1");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      step(3);
      check("R1 arb", arb_lost_flag, 1'b0);
      check("R1 pulse", to_slave_pulse, 1'b0);
      rst_n = 1'b1;
      step(4);
      check("R1 arb", arb_lost_flag, 1'b0);
      check("R1 berr", bus_err_flag, 1'b0);
      check("R1 release", release_req, 1'b0);
      check("R1 pulse", to_slave_pulse, 1'b0);
      check("R1 irq", irq, 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         logic [9:0] v;
         string tag;
         v = VEC[i];
         if (v[9] == 1'b0)        tag = "R3/R4/R11 vector";
         else if (v[6:5] == 2'd0) tag = "R8 vector";
         else                     tag = "R7 vector";
         scl_pin = 1'b0;
         step(3);
         role_master = v[8];
         role_tx     = v[7];
         phase       = v[6:5];
         drive_high  = v[4];
         sda_pin     = v[3];
         step(4);
         scl_pin = 1'b1;
         step(4);
         if (v[9]) begin
            sda_pin = v[2];
            step(4);
         end
         check(tag, arb_lost_flag, v[1]);
         check(tag, bus_err_flag, v[0]);
         check("R10 irq", irq, v[1] | v[0]);
         scl_pin = 1'b0;
         step(2);
         phase = 2'd0;
         drive_high = 1'b0;
         step(2);
         clear_both();
      end

      // Directed: latency, pulse, release and per-flag clear
      scl_pin = 1'b0; sda_pin = 1'b0;
      role_master = 1'b1; role_tx = 1'b1; phase = 2'd2; drive_high = 1'b1;
      step(4);
      scl_pin = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R2 early", arb_lost_flag, 1'b0);
      step(1);
      check("R2 set", arb_lost_flag, 1'b1);
      check("R5 pulse", to_slave_pulse, 1'b1);
      check("R6 release", release_req, 1'b1);
      step(1);
      check("R5 pulse end", to_slave_pulse, 1'b0);
      check("R6 hold", release_req, 1'b1);
      drive_high = 1'b0;
      sda_pin = 1'b1;
      step(4);
      check("R7 rise", bus_err_flag, 1'b1);
      clr_arb = 1'b1;
      step(1);
      clr_arb = 1'b0;
      check("R9 arb cleared", arb_lost_flag, 1'b0);
      check("R9 berr kept", bus_err_flag, 1'b1);
      err_irq_en = 1'b0;
      step(1);
      check("R10 masked", irq, 1'b0);
      err_irq_en = 1'b1;
      step(1);
      check("R10 enabled", irq, 1'b1);
      check("R6 still", release_req, 1'b1);
      scl_pin = 1'b0;
      step(3);
      phase = 2'd0;
      step(1);
      check("R6 drop", release_req, 1'b0);
      clr_berr = 1'b1;
      step(1);
      clr_berr = 1'b0;
      check("R9 berr cleared", bus_err_flag, 1'b0);
      check("R10 idle", irq, 1'b0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule